// File: doc/BRIEF.md
# DDR Command Turnaround Guard

This block sits between a memory command scheduler and the command bus of a set of DDR DIMMs. Each cycle the scheduler may offer one read or write command tagged with its target DIMM and rank. The guard compares the cycles elapsed since the most recent granted read and the most recent granted write to that same DIMM against five programmable turnaround minimums. It grants the command in the same cycle when every limit that applies is met, and raises a stall otherwise.

The limits come from one 32-bit timing word that software sets to the worst case over all DDR ports, so a single set of limits covers every port. Each DIMM keeps its own history of elapsed cycles and last ranks. Commands to different DIMMs never hold each other back. The elapsed counters stop at their maximum value, so a long idle period cannot make an old command look recent.

Top module: `turnaround_guard`

## Requirements
- R1: After reset no DIMM has any command history. The first command offered to any DIMM is granted at once, whatever the limits are.
- R2: `grant_o` and `stall_o` are never high together. With `cmd_valid_i` low both are low. With it high, exactly one of them is high in the same cycle.
- R3: A write is stalled while fewer cycles than the write-to-write limit (timing bits 3:0) have passed since the last granted write to the same DIMM. Elapsed cycles are counted as 1 in the cycle after the grant.
- R4: A write is stalled while fewer cycles than the read-to-write limit (timing bits 15:12) have passed since the last granted read to the same DIMM, whatever the ranks.
- R5: A read to the same rank as the last granted write on its DIMM is stalled until the same-rank write-to-read limit (timing bits 11:8) has passed.
- R6: A read to a different rank from the last granted write on its DIMM is stalled until the different-rank write-to-read limit (timing bits 18:16) has passed.
- R7: A read to a different rank from the last granted read on its DIMM is stalled until the read-to-read limit (timing bits 7:4) has passed. A read to the same rank as the last read is not limited by it.
- R8: A limit of zero places no restriction. Timing bits 31:19 have no effect.
- R9: Commands to different DIMMs do not constrain each other.
- R10: The elapsed counts saturate. After any idle period longer than the largest limit, a command to the DIMM is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is offered this cycle |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_dimm_i | input | DIMM_W | Target DIMM |
| cmd_rank_i | input | RANK_W | Target rank within the DIMM |
| timing_i | input | 32 | Packed turnaround limits in core cycles |
| grant_o | output | 1 | Command may issue this cycle |
| stall_o | output | 1 | Command is held by a turnaround limit |

## Verification
The history of each DIMM is the only state. A stale or wrongly cleared counter shows at the ports as a grant that comes one or more cycles too early or too late at the boundary of a limit. The bench catches this by offering the follow-up command in every cycle and checking that the first grant lands exactly on the programmed count. A wrong stored rank picks the wrong write-to-read or read-to-read limit, and this shows on the first read after a write or read to another rank. A counter that wraps instead of saturating shows only after a long idle period, as a stall that should not happen.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int LIM_W = 4;

  typedef struct packed {
    logic [LIM_W-1:0] wr2rd_diff;
    logic [LIM_W-1:0] rd2wr;
    logic [LIM_W-1:0] wr2rd_same;
    logic [LIM_W-1:0] rd2rd;
    logic [LIM_W-1:0] wr2wr;
  } tg_limits_t;

  function automatic tg_limits_t tg_unpack(input logic [31:0] w);
    tg_limits_t l;
    l.wr2rd_diff = {1'b0, w[18:16]};
    l.rd2wr      = w[15:12];
    l.wr2rd_same = w[11:8];
    l.rd2rd      = w[7:4];
    l.wr2wr      = w[3:0];
    return l;
  endfunction
endpackage

// File: rtl/tg_dimm_track.sv
module tg_dimm_track #(
  parameter int CNT_W  = 4,
  parameter int RANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_rd_i,
  input  logic              upd_wr_i,
  input  logic [RANK_W-1:0] rank_i,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic [CNT_W-1:0]  wr_cnt_o,
  output logic [RANK_W-1:0] rd_rank_o,
  output logic [RANK_W-1:0] wr_rank_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // saturated at reset: no history means no restriction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_o  <= CNT_MAX;
      wr_cnt_o  <= CNT_MAX;
      rd_rank_o <= '0;
      wr_rank_o <= '0;
    end else begin
      if (upd_rd_i) begin
        rd_cnt_o  <= CNT_ONE;
        rd_rank_o <= rank_i;
      end else if (rd_cnt_o != CNT_MAX) begin
        rd_cnt_o <= rd_cnt_o + CNT_ONE;
      end
      if (upd_wr_i) begin
        wr_cnt_o  <= CNT_ONE;
        wr_rank_o <= rank_i;
      end else if (wr_cnt_o != CNT_MAX) begin
        wr_cnt_o <= wr_cnt_o + CNT_ONE;
      end
    end
  end
endmodule

// File: rtl/tg_rule_check.sv
module tg_rule_check
  import tg_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int RANK_W = 2
) (
  input  tg_limits_t        lim_i,
  input  logic              is_write_i,
  input  logic [RANK_W-1:0] rank_i,
  input  logic [CNT_W-1:0]  rd_cnt_i,
  input  logic [CNT_W-1:0]  wr_cnt_i,
  input  logic [RANK_W-1:0] rd_rank_i,
  input  logic [RANK_W-1:0] wr_rank_i,
  output logic              ok_o
);
  logic ok_wr2wr, ok_rd2wr, ok_wr2rd, ok_rd2rd;
  logic [CNT_W-1:0] wr2rd_lim;

  always_comb begin
    wr2rd_lim = (wr_rank_i == rank_i) ? CNT_W'(lim_i.wr2rd_same) : CNT_W'(lim_i.wr2rd_diff);
    ok_wr2wr  = wr_cnt_i >= CNT_W'(lim_i.wr2wr);
    ok_rd2wr  = rd_cnt_i >= CNT_W'(lim_i.rd2wr);
    ok_wr2rd  = wr_cnt_i >= wr2rd_lim;
    ok_rd2rd  = (rd_rank_i == rank_i) || (rd_cnt_i >= CNT_W'(lim_i.rd2rd));
    ok_o      = is_write_i ? (ok_wr2wr && ok_rd2wr) : (ok_wr2rd && ok_rd2rd);
  end
endmodule

// File: rtl/turnaround_guard.sv
module turnaround_guard
  import tg_pkg::*;
#(
  parameter int NUM_DIMMS = 4,
  parameter int NUM_RANKS = 4,
  parameter int CNT_W     = 4,
  localparam int DIMM_W   = (NUM_DIMMS > 1) ? $clog2(NUM_DIMMS) : 1,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  logic [DIMM_W-1:0] cmd_dimm_i,
  input  logic [RANK_W-1:0] cmd_rank_i,
  input  logic [31:0]       timing_i,
  output logic              grant_o,
  output logic              stall_o
);
  tg_limits_t        lim;
  logic [CNT_W-1:0]  rd_cnt  [NUM_DIMMS];
  logic [CNT_W-1:0]  wr_cnt  [NUM_DIMMS];
  logic [RANK_W-1:0] rd_rank [NUM_DIMMS];
  logic [RANK_W-1:0] wr_rank [NUM_DIMMS];
  logic              ok;

  assign lim = tg_unpack(timing_i);

  for (genvar d = 0; d < NUM_DIMMS; d++) begin : g_dimm
    logic hit;
    assign hit = grant_o && (int'(cmd_dimm_i) == d);
    tg_dimm_track #(.CNT_W(CNT_W), .RANK_W(RANK_W)) u_track (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .upd_rd_i (hit && !cmd_write_i),
      .upd_wr_i (hit && cmd_write_i),
      .rank_i   (cmd_rank_i),
      .rd_cnt_o (rd_cnt[d]),
      .wr_cnt_o (wr_cnt[d]),
      .rd_rank_o(rd_rank[d]),
      .wr_rank_o(wr_rank[d])
    );
  end

  tg_rule_check #(.CNT_W(CNT_W), .RANK_W(RANK_W)) u_rule (
    .lim_i     (lim),
    .is_write_i(cmd_write_i),
    .rank_i    (cmd_rank_i),
    .rd_cnt_i  (rd_cnt[cmd_dimm_i]),
    .wr_cnt_i  (wr_cnt[cmd_dimm_i]),
    .rd_rank_i (rd_rank[cmd_dimm_i]),
    .wr_rank_i (wr_rank[cmd_dimm_i]),
    .ok_o      (ok)
  );

  assign grant_o = cmd_valid_i && ok;
  assign stall_o = cmd_valid_i && !ok;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_write_i,
  input logic [DIMM_W-1:0] cmd_dimm_i,
  input logic [RANK_W-1:0] cmd_rank_i,
  input logic [31:0]       timing_i,
  input logic              grant_o,
  input logic              stall_o
);
  p_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && stall_o));

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |-> (!grant_o && !stall_o));

  p_wr2wr_b2b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && cmd_write_i && timing_i[3:0] >= 4'd2) |=>
    !(grant_o && cmd_write_i && cmd_dimm_i == $past(cmd_dimm_i) && $stable(timing_i)));

  p_rd2wr_b2b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !cmd_write_i && timing_i[15:12] >= 4'd2) |=>
    !(grant_o && cmd_write_i && cmd_dimm_i == $past(cmd_dimm_i) && $stable(timing_i)));

  p_wr2rd_same_b2b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && cmd_write_i && timing_i[11:8] >= 4'd2) |=>
    !(grant_o && !cmd_write_i && cmd_dimm_i == $past(cmd_dimm_i)
      && cmd_rank_i == $past(cmd_rank_i) && $stable(timing_i)));
endmodule

bind turnaround_guard tg_checker #(.DIMM_W(DIMM_W), .RANK_W(RANK_W)) u_tg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_write_i(cmd_write_i),
  .cmd_dimm_i (cmd_dimm_i),
  .cmd_rank_i (cmd_rank_i),
  .timing_i   (timing_i),
  .grant_o    (grant_o),
  .stall_o    (stall_o)
);

// File: tb/turnaround_guard_bench.sv
module turnaround_guard_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic       cmd_write_i = 1'b0;
  logic [1:0] cmd_dimm_i = '0;
  logic [1:0] cmd_rank_i = '0;
  logic [31:0] timing_i = '0;
  logic       grant_o, stall_o;
  int n_run = 0, n_fail = 0;

  localparam logic [31:0] T_STD = 32'h0005_4632; // wr2rd_diff 5, rd2wr 4, wr2rd_same 6, rd2rd 3, wr2wr 2

  turnaround_guard u_turnaround_guard (.*);

  always #2 clk_i = ~clk_i;

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic do_reset(input logic [31:0] t);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    timing_i = t;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      cmd_valid_i = 1'b0;
    end
  endtask

  // offer a command, check grant/stall in the same cycle
  task automatic offer(input logic w, input logic [1:0] d, input logic [1:0] r,
                       input logic exp_g, input string req);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_write_i = w; cmd_dimm_i = d; cmd_rank_i = r;
    #1;
    n_run++;
    if (grant_o !== exp_g || stall_o !== !exp_g) begin
      n_fail++;
      $display("FAIL %s: actual grant=%b stall=%b expected grant=%b stall=%b",
               req, grant_o, stall_o, exp_g, !exp_g);
    end
  endtask

  task automatic t_reset_r1;
    do_reset(32'h0007_FFFF);
    #1; n_run++;
    if (grant_o !== 1'b0 || stall_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: actual grant=%b stall=%b expected 0 0", grant_o, stall_o);
    end
    offer(1'b1, 2'd0, 2'd0, 1'b1, "R1");
    offer(1'b0, 2'd1, 2'd3, 1'b1, "R1");
  endtask

  task automatic t_wr2wr_r3;
    do_reset(T_STD);
    offer(1'b1, 2'd0, 2'd0, 1'b1, "R3");
    offer(1'b1, 2'd0, 2'd0, 1'b0, "R3");
    offer(1'b1, 2'd0, 2'd0, 1'b1, "R3");
  endtask

  task automatic t_rd2wr_r4;
    do_reset(T_STD);
    offer(1'b0, 2'd0, 2'd0, 1'b1, "R4");
    for (int i = 1; i < 4; i++) offer(1'b1, 2'd0, 2'd1, 1'b0, "R4");
    offer(1'b1, 2'd0, 2'd1, 1'b1, "R4");
  endtask

  task automatic t_wr2rd_same_r5;
    do_reset(T_STD);
    offer(1'b1, 2'd0, 2'd2, 1'b1, "R5");
    for (int i = 1; i < 6; i++) offer(1'b0, 2'd0, 2'd2, 1'b0, "R5");
    offer(1'b0, 2'd0, 2'd2, 1'b1, "R5");
  endtask

  task automatic t_wr2rd_diff_r6;
    do_reset(T_STD);
    offer(1'b1, 2'd0, 2'd2, 1'b1, "R6");
    for (int i = 1; i < 5; i++) offer(1'b0, 2'd0, 2'd1, 1'b0, "R6");
    offer(1'b0, 2'd0, 2'd1, 1'b1, "R6");
  endtask

  task automatic t_rd2rd_r7;
    do_reset(T_STD);
    offer(1'b0, 2'd0, 2'd0, 1'b1, "R7");
    offer(1'b0, 2'd0, 2'd0, 1'b1, "R7");
    offer(1'b0, 2'd0, 2'd3, 1'b0, "R7");
    offer(1'b0, 2'd0, 2'd3, 1'b0, "R7");
    offer(1'b0, 2'd0, 2'd3, 1'b1, "R7");
  endtask

  task automatic t_zero_r8;
    do_reset(32'h0000_0000);
    offer(1'b1, 2'd0, 2'd0, 1'b1, "R8");
    offer(1'b0, 2'd0, 2'd0, 1'b1, "R8");
    offer(1'b1, 2'd0, 2'd1, 1'b1, "R8");
    do_reset(32'hFFF8_0000);
    offer(1'b1, 2'd0, 2'd0, 1'b1, "R8");
    offer(1'b0, 2'd0, 2'd1, 1'b1, "R8");
    offer(1'b0, 2'd0, 2'd2, 1'b1, "R8");
  endtask

  task automatic t_cross_r9;
    do_reset(T_STD);
    offer(1'b1, 2'd0, 2'd0, 1'b1, "R9");
    offer(1'b0, 2'd1, 2'd0, 1'b1, "R9");
    offer(1'b1, 2'd2, 2'd0, 1'b1, "R9");
    offer(1'b0, 2'd0, 2'd0, 1'b0, "R9");
  endtask

  task automatic t_sat_r10;
    do_reset(32'h0007_FFFF);
    offer(1'b1, 2'd0, 2'd0, 1'b1, "R10");
    idle(40);
    offer(1'b1, 2'd0, 2'd0, 1'b1, "R10");
    offer(1'b1, 2'd0, 2'd0, 1'b0, "R10");
  endtask

  initial begin
    t_reset_r1();
    t_wr2wr_r3();
    t_rd2wr_r4();
    t_wr2rd_same_r5();
    t_wr2rd_diff_r6();
    t_rd2rd_r7();
    t_zero_r8();
    t_cross_r9();
    t_sat_r10();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule